// File: doc/BRIEF.md
# Gaussian-Mixture Class Posterior Pipeline

This block turns one expanded feature vector into a set of class posterior probabilities. The classifier has C classes, each built from M mixture components. The H features of a vector arrive one per cycle. Each component then forms a weighted sum of the features, and that sum goes out to an external exponential unit. The exponentials of all components are normalised by their grand total, and the normalised values of each class are summed to give that class's output. The exponential approximation is a separate block. It is reached through a request/valid interface.

The weights sit in a simple dual-port memory that can map to block RAM. They are loaded through a write port that selects a component and a feature index. The final component of the final class is the reference component. It has no stored weights, and its weighted sum is always zero. All arithmetic is fixed point: features and weights are signed with FRAC fraction bits. Outputs are unsigned Q1.15, so 1.0 is 32768. Normalisation runs one component at a time through a sequential restoring divider.

Top module: `mixture_posterior`

## Requirements
- R1: While `rst` is high and after its release, `done` is 0 and every class output field of `cls_out` is 0 until the first result.
- R2: For each non-reference component k, the argument sent on `exp_arg` equals (sum over h of feature h times weight (k,h)) arithmetically shifted right by FRAC.
- R3: The reference component (index C*M-1) always sends argument 0. Writes with `wr_comp` = C*M-1 are ignored.
- R4: Each vector makes exactly C*M single-cycle `exp_req` pulses, in component order 0 to C*M-1. The block waits for `exp_vld` after each pulse before it moves on.
- R5: The normalised value of component k is floor(e_k * 32768 / total), where total is the sum of all returned exponentials. A value above 32768, or a zero total, gives 32768. Class c (field `cls_out[c*16 +: 16]`) is the sum of the normalised values of components c*M to c*M+M-1, capped at 32768.
- R6: `done` is a one-cycle pulse after the last division. `cls_out` changes only in that cycle and holds until the next pulse.
- R7: With a non-zero total, the class outputs of one result sum to a value between 32768-C*M and 32768.
- R8: A shifted weighted sum outside the signed EAW-bit range is clipped to the nearest end of that range before it is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Weight write strobe |
| wr_comp | input | KW | Component index of the write |
| wr_idx | input | HW | Feature index of the write |
| wr_data | input | WW | Signed weight value |
| feat_vld | input | 1 | Feature sample valid |
| feat_data | input | FW | Signed feature sample, in order 0 to H-1 |
| exp_req | output | 1 | Exponential request pulse |
| exp_arg | output | EAW | Signed argument, FRAC fraction bits |
| exp_vld | input | 1 | Exponential result valid |
| exp_res | input | EVW | Unsigned exponential result |
| done | output | 1 | Result-ready pulse |
| cls_out | output | C*16 | Class posteriors, unsigned Q1.15, class c at bits c*16 upward |

## Verification
The bench builds the block with its defaults: two classes of two components, six features, 16-bit Q7.8 features and weights, and 24-bit exponentials with 12 fraction bits. With these sizes the bench can drive a 16-bit feature to its limit and push a weighted sum past both ends of the argument range. It can also make the ideal exponential model overflow to its cap. A zero-returning mode of the model reaches the zero-total saturation path. The reference component sits in the second class, so writes aimed at it can be shown to leave the class sums unchanged.

// File: rtl/mp_pkg.sv
package mp_pkg;
  localparam int QW = 16;
  localparam int ONE_Q = 1 << (QW - 1);

  typedef enum logic [2:0] {
    S_LOAD, S_MAC, S_DRAIN, S_EXP_REQ, S_EXP_WAIT, S_DIV_START, S_DIV_WAIT
  } state_t;
endpackage

// File: rtl/mp_weight_ram.sv
module mp_weight_ram #(
  parameter int DW = 16,
  parameter int DEPTH = 18,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic signed [DW-1:0] wdata,
  input  logic [AW-1:0]        raddr,
  output logic signed [DW-1:0] rdata
);
  logic signed [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mp_mac.sv
module mp_mac #(
  parameter int FW = 16,
  parameter int WW = 16,
  parameter int ACCW = 36
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   en,
  input  logic signed [FW-1:0]   a,
  input  logic signed [WW-1:0]   b,
  output logic signed [ACCW-1:0] acc
);
  logic signed [FW+WW-1:0] prod;
  assign prod = a * b;

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (en)    acc <= acc + ACCW'(prod);
  end
endmodule

// File: rtl/mp_div.sv
module mp_div #(
  parameter int NW = 39,
  parameter int DW = 26,
  localparam int CW = $clog2(NW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [NW-1:0] quo
);
  logic [DW-1:0] rem;
  logic [NW-1:0] nsh;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [DW:0]   trial;
  logic          fits;

  always_comb begin
    trial = {rem, nsh[NW-1]};
    fits  = (trial >= {1'b0, den});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0; nsh <= '0; quo <= '0; cnt <= '0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem  <= '0;
        nsh  <= num;
        quo  <= '0;
        cnt  <= CW'(NW);
        busy <= 1'b1;
      end else if (busy) begin
        rem <= fits ? DW'(trial - {1'b0, den}) : trial[DW-1:0];
        quo <= {quo[NW-2:0], fits};
        nsh <= {nsh[NW-2:0], 1'b0};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mixture_posterior.sv
module mixture_posterior #(
  parameter int C = 2,
  parameter int M = 2,
  parameter int H = 6,
  parameter int FW = 16,
  parameter int WW = 16,
  parameter int FRAC = 8,
  parameter int EAW = 16,
  parameter int EVW = 24,
  localparam int K = C * M,
  localparam int KW = $clog2(K),
  localparam int HW = $clog2(H),
  localparam int DEPTH = (K - 1) * H,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int QW = mp_pkg::QW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [KW-1:0]     wr_comp,
  input  logic [HW-1:0]     wr_idx,
  input  logic [WW-1:0]     wr_data,
  input  logic              feat_vld,
  input  logic [FW-1:0]     feat_data,
  output logic              exp_req,
  output logic [EAW-1:0]    exp_arg,
  input  logic              exp_vld,
  input  logic [EVW-1:0]    exp_res,
  output logic              done,
  output logic [C*QW-1:0]   cls_out
);
  import mp_pkg::*;

  localparam int ACCW = FW + WW + HW + 1;
  localparam int TW = EVW + KW;
  localparam int NW = EVW + QW - 1;
  localparam longint AMAX = (64'sd1 <<< (EAW - 1)) - 1;
  localparam longint AMIN = -(64'sd1 <<< (EAW - 1));

  state_t st;
  logic [HW-1:0] h_cnt, rd_h;
  logic [KW-1:0] comp;
  logic          rd_v;
  logic signed [FW-1:0] fbuf [H];
  logic [EVW-1:0] expv [K];
  logic [TW-1:0]  total;
  logic [QW-1:0]  cls_acc [C];

  // weight store: reference component has no entries
  logic          ram_we;
  logic [AW-1:0] ram_waddr, ram_raddr;
  logic signed [WW-1:0] ram_rdata;

  assign ram_we    = wr_en && (int'(wr_comp) != K - 1) && (int'(wr_idx) < H);
  assign ram_waddr = AW'(int'(wr_comp) * H + int'(wr_idx));
  assign ram_raddr = AW'(int'(comp) * H + int'(h_cnt));

  mp_weight_ram #(.DW(WW), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(signed'(wr_data)),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  // multiply-accumulate over the features of one component
  logic load_last, mac_clr;
  logic signed [ACCW-1:0] acc, shifted;
  assign load_last = (st == S_LOAD) && feat_vld && (int'(h_cnt) == H - 1);
  assign mac_clr   = load_last || ((st == S_EXP_WAIT) && exp_vld);

  mp_mac #(.FW(FW), .WW(WW), .ACCW(ACCW)) u_mac (
    .clk(clk), .rst(rst), .clr(mac_clr), .en(rd_v),
    .a(fbuf[rd_h]), .b(ram_rdata), .acc(acc)
  );

  // argument scaling by shift, then clipping to the argument range
  logic [EAW-1:0] arg_next;
  always_comb begin
    shifted = acc >>> FRAC;
    if (int'(comp) == K - 1)         arg_next = '0;
    else if (longint'(shifted) > AMAX) arg_next = EAW'(AMAX);
    else if (longint'(shifted) < AMIN) arg_next = EAW'(AMIN);
    else                              arg_next = EAW'(shifted);
  end

  // normalisation divider
  logic          div_start, div_done;
  logic [NW-1:0] div_num, div_quo;
  assign div_start = (st == S_DIV_START);
  assign div_num   = {expv[comp], {(QW-1){1'b0}}};

  mp_div #(.NW(NW), .DW(TW)) u_div (
    .clk(clk), .rst(rst), .start(div_start), .num(div_num), .den(total),
    .done(div_done), .quo(div_quo)
  );

  // saturating class accumulation
  logic [QW-1:0] q_sat, cls_new;
  logic [QW:0]   cls_sum;
  int            ci;
  always_comb begin
    ci      = int'(comp) / M;
    q_sat   = (div_quo > NW'(ONE_Q)) ? QW'(ONE_Q) : div_quo[QW-1:0];
    cls_sum = {1'b0, cls_acc[ci]} + {1'b0, q_sat};
    cls_new = (cls_sum > (QW+1)'(ONE_Q)) ? QW'(ONE_Q) : cls_sum[QW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_LOAD;
      h_cnt   <= '0;
      rd_h    <= '0;
      rd_v    <= 1'b0;
      comp    <= '0;
      total   <= '0;
      exp_req <= 1'b0;
      exp_arg <= '0;
      done    <= 1'b0;
      cls_out <= '0;
      for (int c = 0; c < C; c++) cls_acc[c] <= '0;
    end else begin
      exp_req <= 1'b0;
      done    <= 1'b0;
      rd_v    <= (st == S_MAC);
      rd_h    <= h_cnt;
      unique case (st)
        S_LOAD: if (feat_vld) begin
          fbuf[h_cnt] <= signed'(feat_data);
          if (load_last) begin
            h_cnt <= '0;
            comp  <= '0;
            total <= '0;
            for (int c = 0; c < C; c++) cls_acc[c] <= '0;
            st    <= (K == 1) ? S_EXP_REQ : S_MAC;
          end else begin
            h_cnt <= h_cnt + 1'b1;
          end
        end
        S_MAC: begin
          if (int'(h_cnt) == H - 1) begin
            h_cnt <= '0;
            st    <= S_DRAIN;
          end else begin
            h_cnt <= h_cnt + 1'b1;
          end
        end
        S_DRAIN: st <= S_EXP_REQ;
        S_EXP_REQ: begin
          exp_req <= 1'b1;
          exp_arg <= arg_next;
          st      <= S_EXP_WAIT;
        end
        S_EXP_WAIT: if (exp_vld) begin
          expv[comp] <= exp_res;
          total      <= total + TW'(exp_res);
          if (int'(comp) == K - 1) begin
            comp <= '0;
            st   <= S_DIV_START;
          end else begin
            comp <= comp + 1'b1;
            st   <= (int'(comp) + 1 == K - 1) ? S_EXP_REQ : S_MAC;
          end
        end
        S_DIV_START: st <= S_DIV_WAIT;
        S_DIV_WAIT: if (div_done) begin
          cls_acc[ci] <= cls_new;
          if (int'(comp) == K - 1) begin
            for (int c = 0; c < C; c++)
              cls_out[c*QW +: QW] <= (c == ci) ? cls_new : cls_acc[c];
            done  <= 1'b1;
            comp  <= '0;
            h_cnt <= '0;
            st    <= S_LOAD;
          end else begin
            comp <= comp + 1'b1;
            st   <= S_DIV_START;
          end
        end
        default: st <= S_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/mp_check.sv
module mp_check #(
  parameter int C = 2,
  parameter int M = 2,
  parameter int EAW = 16,
  parameter int KW = 2,
  parameter int QW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            exp_req,
  input logic [EAW-1:0]  exp_arg,
  input logic            done,
  input logic [C*QW-1:0] cls_out,
  input logic [KW-1:0]   comp
);
  localparam int ONE = 1 << (QW - 1);

  function automatic int out_sum(input logic [C*QW-1:0] v);
    int s = 0;
    for (int c = 0; c < C; c++) s += int'(v[c*QW +: QW]);
    return s;
  endfunction

  // R4: a request lasts exactly one cycle
  a_r4_req_pulse: assert property (@(posedge clk) disable iff (rst)
    exp_req |=> !exp_req);

  // R3: the reference component always asks for exp(0)
  a_r3_ref_zero: assert property (@(posedge clk) disable iff (rst)
    (exp_req && int'(comp) == C*M - 1) |-> (exp_arg == '0));

  // R6: done is a single pulse and outputs move only with it
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(cls_out));

  // R7: results add up to no less than one minus the rounding loss
  a_r7_sum: assert property (@(posedge clk) disable iff (rst)
    done |-> (out_sum(cls_out) >= ONE - C*M));

  // R5: each class output is capped at 1.0
  for (genvar c = 0; c < C; c++) begin : g_cap
    a_r5_cap: assert property (@(posedge clk) disable iff (rst)
      int'(cls_out[c*QW +: QW]) <= ONE);
  end
endmodule

bind mixture_posterior mp_check #(
  .C(C), .M(M), .EAW(EAW), .KW(KW), .QW(QW)
) u_mp_check (
  .clk(clk), .rst(rst), .exp_req(exp_req), .exp_arg(exp_arg),
  .done(done), .cls_out(cls_out), .comp(comp)
);

// File: tb/mixture_posterior_bench.sv
module mixture_posterior_bench;
  localparam int C = 2, M = 2, H = 6, FW = 16, WW = 16, FRAC = 8;
  localparam int EAW = 16, EVW = 24, K = C * M, KW = 2, HW = 3, QW = 16;
  localparam int ONE = 32768;
  localparam int NV = 5;

  // weights of the three stored components, Q7.8
  localparam int WTAB [(K-1)*H] = '{
    128,  256,  256, -64,    0, -64,
      0, -256, -256, -64,   32, -64,
    -64,  256, -256,   0, -128,   0 };
  // stimulus vectors, H features each, Q7.8
  localparam int VTAB [NV*H] = '{
    256,  128,  -64,  64,  -32,  16,
    256, -300,  200, 351, -234, 156,
      0,    0,    0,   0,    0,   0,
    256,  512,  512, 1024, 1024, 1024,
    256, -128, -128,  64,   64,  64 };

  logic clk = 0, rst = 1;
  logic wr_en = 0;
  logic [KW-1:0] wr_comp = '0;
  logic [HW-1:0] wr_idx = '0;
  logic [WW-1:0] wr_data = '0;
  logic feat_vld = 0;
  logic [FW-1:0] feat_data = '0;
  logic exp_req, exp_vld = 0, done;
  logic [EAW-1:0] exp_arg;
  logic [EVW-1:0] exp_res = '0;
  logic [C*QW-1:0] cls_out;

  mixture_posterior u_mixture_posterior (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_comp(wr_comp), .wr_idx(wr_idx),
    .wr_data(wr_data), .feat_vld(feat_vld), .feat_data(feat_data),
    .exp_req(exp_req), .exp_arg(exp_arg), .exp_vld(exp_vld),
    .exp_res(exp_res), .done(done), .cls_out(cls_out));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  bit zero_mode = 0;
  int arg_log [8];
  int arg_n = 0;
  int e_arg [K];
  int e_cls [C];
  int feat [H];

  task automatic check(input string req, input longint act, input longint expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int ideal_exp(input int a);
    real r;
    if (zero_mode) return 0;
    r = $exp(real'(a) / 256.0) * 4096.0;
    if (r > 16777215.0) return 16777215;
    return $rtoi(r + 0.5);
  endfunction

  // ideal exponential unit: answers one cycle after each request
  initial forever begin
    @(posedge clk);
    if (exp_req) begin
      if (arg_n < 8) arg_log[arg_n] = int'(signed'(exp_arg));
      arg_n++;
      @(posedge clk);
      #1 exp_res = EVW'(ideal_exp(int'(signed'(exp_arg))));
      exp_vld = 1;
      @(posedge clk);
      #1 exp_vld = 0;
    end
  end

  task automatic model();
    longint e [K];
    longint total = 0, s, q;
    for (int c = 0; c < C; c++) e_cls[c] = 0;
    for (int k = 0; k < K; k++) begin
      s = 0;
      if (k != K - 1)
        for (int h = 0; h < H; h++) s += longint'(feat[h]) * WTAB[k*H + h];
      s = s >>> FRAC;
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      e_arg[k] = int'(s);
      e[k] = ideal_exp(e_arg[k]);
      total += e[k];
    end
    for (int k = 0; k < K; k++) begin
      q = (total == 0) ? ONE : (e[k] * ONE) / total;
      if (q > ONE) q = ONE;
      e_cls[k / M] += int'(q);
      if (e_cls[k / M] > ONE) e_cls[k / M] = ONE;
    end
  endtask

  task automatic run(input string tag);
    int wait_n = 0, sum = 0;
    arg_n = 0;
    model();
    for (int h = 0; h < H; h++) begin
      @(posedge clk); #1 feat_vld = 1; feat_data = FW'(feat[h]);
    end
    @(posedge clk); #1 feat_vld = 0;
    while (!done && wait_n < 2000) begin
      @(posedge clk); #1 wait_n++;
    end
    check({tag, " R6 done seen"}, done, 1);
    for (int c = 0; c < C; c++) begin
      check({tag, " R5 class value"}, cls_out[c*QW +: QW], e_cls[c]);
      sum += int'(cls_out[c*QW +: QW]);
    end
    check({tag, " R4 request count"}, arg_n, K);
    for (int k = 0; k < K; k++)
      check({tag, " R2/R8 argument"}, arg_log[k], e_arg[k]);
    check({tag, " R3 reference arg"}, arg_log[K-1], 0);
    if (!zero_mode) begin
      check({tag, " R7 sum low"}, sum >= ONE - K, 1);
      check({tag, " R7 sum high"}, sum <= ONE, 1);
    end
    @(posedge clk); #1;
    check({tag, " R6 single pulse"}, done, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 done in reset", done, 0);
    check("R1 outputs in reset", cls_out, 0);
    rst = 0;
    @(posedge clk); #1;
    check("R1 done after reset", done, 0);
    check("R1 outputs after reset", cls_out, 0);

    for (int k = 0; k < K - 1; k++)
      for (int h = 0; h < H; h++) begin
        @(posedge clk); #1;
        wr_en = 1; wr_comp = KW'(k); wr_idx = HW'(h); wr_data = WW'(WTAB[k*H + h]);
      end
    @(posedge clk); #1 wr_en = 0;

    // table walk: R2, R4, R5, R7 under several patterns
    for (int v = 0; v < NV; v++) begin
      for (int h = 0; h < H; h++) feat[h] = VTAB[v*H + h];
      run($sformatf("vec%0d", v));
    end

    // R6: outputs hold between results
    begin
      logic [C*QW-1:0] held;
      held = cls_out;
      repeat (10) @(posedge clk);
      #1 check("R6 hold", cls_out, held);
    end

    // R8: sums beyond both ends of the argument range
    feat = '{0, 32767, 32767, 0, 0, 0};
    run("clip");
    check("R8 upper clip", arg_log[0], 32767);
    check("R8 lower clip", arg_log[1], -32768);

    // R3: writes to the reference component are ignored
    for (int h = 0; h < H; h++) begin
      @(posedge clk); #1;
      wr_en = 1; wr_comp = KW'(K - 1); wr_idx = HW'(h); wr_data = 16'h7fff;
    end
    @(posedge clk); #1 wr_en = 0;
    for (int h = 0; h < H; h++) feat[h] = VTAB[h];
    run("refwr");
    check("R3 class after ignored write", cls_out[QW +: QW], e_cls[1]);

    // R5: zero total saturates every component to 1.0
    zero_mode = 1;
    run("zero");
    for (int c = 0; c < C; c++) check("R5 saturation", cls_out[c*QW +: QW], ONE);
    zero_mode = 0;

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R6 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule